// File: doc/BRIEF.md
# CAN Bit Timing Generator

This block turns the system clock into the bit-level timebase of a CAN node. A programmable divider produces one time-quantum tick every `presc + 1` system clocks. A sequencer then walks every bit through a one-quantum sync segment, a propagation segment, a first phase segment and a second phase segment. The receive line is sampled once per bit, on the last clock of the first phase segment.

The sequencer follows the bus. While the protocol layer reports the bus as idle, a recessive-to-dominant transition forces a hard synchronization that restarts the bit. During a frame, such a transition causes a single resynchronization in that bit. It either stretches the first phase segment or trims the second, and neither change may exceed the programmed jump width.

A separate configuration checker flags settings that cannot work. It also derives how late the transmitter's bit-start strobe must be issued so that the controller's processing time is covered.

The sampled bit leaves on a valid-only stream (`bit_valid`, `bit_value`), with no ready input. The bus cannot be stalled, so the consumer must accept every strobe in the clock it appears. `bit_value` holds until the next strobe. All other pins are plain levels or one-clock pulses.

Top module: `can_bittime_gen`

## Requirements
- R1: `tq_tick` is high for one clock out of every `presc + 1` system clocks.
- R2: A bit lasts 1 + `prop_len` + `ph1_len` + `ph2_len` quanta. `bit_valid` pulses for exactly one clock per bit, in the clock after the last clock of phase 1. It carries in `bit_value` the `rx` level (1 = recessive, 0 = dominant) seen on that last clock.
- R3: `tx_bit_start` pulses in the first clock of quantum d of each bit, where the sync quantum is quantum 0 and d = max(0, IPT − `ph2_len`). IPT is 3 quanta when `presc` = 0 and 2 quanta otherwise.
- R4: `cfg_err` is high whenever `presc` = 0 and `ph2_len` = 0. A zero length field is otherwise treated as one quantum.
- R5: `cfg_err` is high whenever (`presc` + 1) × (bit length in quanta) is below MIN_BIT_CLKS (9) system clocks.
- R6: With `bus_idle` high, a falling `rx` (1 in one clock, 0 in the next) restarts the divider and the bit. The next clock is the first clock of a new sync quantum.
- R7: With `bus_idle` low, a falling `rx` in the propagation or phase-1 segment of quantum q extends phase 1 of that bit by min(q, `sjw`) quanta.
- R8: With `bus_idle` low, a falling `rx` in phase 2 with r quanta left (the current one included) trims phase 2 by `sjw` quanta if r > `sjw`. Otherwise it restarts the bit as in R6.
- R9: Only the first qualifying falling edge of a bit adjusts it. Rising edges adjust nothing.
- R10: After reset, `bit_valid`, `bit_value` and `tx_bit_start` are 0 and the bit starts at its sync quantum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| presc | input | PRESC_W | Divider field; quantum = presc + 1 clocks |
| prop_len | input | LEN_W | Propagation segment length in quanta |
| ph1_len | input | LEN_W | Phase 1 length in quanta |
| ph2_len | input | LEN_W | Phase 2 length in quanta |
| sjw | input | SJW_W | Resynchronization jump width in quanta |
| bus_idle | input | 1 | High between frames; selects hard sync |
| rx | input | 1 | Received bus level, synchronous to clk |
| tq_tick | output | 1 | One-clock pulse, last clock of each quantum |
| bit_valid | output | 1 | One-clock strobe per bit for bit_value |
| bit_value | output | 1 | Sampled bus level |
| tx_bit_start | output | 1 | Bit-start pulse for the transmitter |
| cfg_err | output | 1 | Invalid configuration |

## Verification
The bench uses the default widths (6-bit divider, 4-bit lengths, 3-bit jump width, 9-clock minimum). These make reachable both example rates, a divide-by-1 with 25 quanta and a divide-by-10 with 20 quanta, as well as every legal transmit delay. Most edge scenarios run at a divide-by-1 setting, so each quantum is one clock. Each resynchronization case can then be placed in an exact quantum, and its effect read as a cycle distance between `tx_bit_start` and `bit_valid`.

// File: rtl/cbt_pkg.sv
package cbt_pkg;
  typedef enum logic [1:0] {
    SEG_SYNC = 2'd0,
    SEG_PROP = 2'd1,
    SEG_PH1  = 2'd2,
    SEG_PH2  = 2'd3
  } seg_e;
endpackage

// File: rtl/cbt_tq_div.sv
module cbt_tq_div #(
  parameter int PRESC_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PRESC_W-1:0] presc,
  input  logic               restart,
  output logic               tick
);
  logic [PRESC_W-1:0] pc;

  assign tick = (pc >= presc);

  always_ff @(posedge clk) begin
    if (!rst_n)               pc <= '0;
    else if (restart || tick) pc <= '0;
    else                      pc <= pc + 1'b1;
  end

  // R1
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && presc != '0 && !restart && $stable(presc)) |=> (!tick || presc == '0));
endmodule

// File: rtl/cbt_cfg_chk.sv
module cbt_cfg_chk #(
  parameter int PRESC_W      = 6,
  parameter int LEN_W        = 4,
  parameter int MIN_BIT_CLKS = 9
) (
  input  logic [PRESC_W-1:0] presc,
  input  logic [LEN_W-1:0]   ph2_raw,
  input  logic [LEN_W-1:0]   propc,
  input  logic [LEN_W-1:0]   ph1c,
  input  logic [LEN_W-1:0]   ph2c,
  output logic               cfg_err,
  output logic [1:0]         tx_dly
);
  localparam int BC_W = PRESC_W + LEN_W + 3;

  logic [BC_W-1:0] div_f, quanta, bit_clks;
  logic [LEN_W-1:0] ipt;

  always_comb begin
    div_f    = BC_W'(presc) + BC_W'(1);
    quanta   = BC_W'(1) + BC_W'(propc) + BC_W'(ph1c) + BC_W'(ph2c);
    bit_clks = div_f * quanta;
    cfg_err  = ((presc == '0) && (ph2_raw == '0)) || (bit_clks < BC_W'(MIN_BIT_CLKS));
    ipt      = (presc == '0) ? LEN_W'(3) : LEN_W'(2);
    tx_dly   = (ph2c < ipt) ? 2'(ipt - ph2c) : 2'd0;
  end
endmodule

// File: rtl/cbt_seq.sv
module cbt_seq
  import cbt_pkg::*;
#(
  parameter int LEN_W = 4,
  parameter int SJW_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [LEN_W-1:0] propc,
  input  logic [LEN_W-1:0] ph1c,
  input  logic [LEN_W-1:0] ph2c,
  input  logic [SJW_W-1:0] sjw,
  input  logic [1:0]       tx_dly,
  input  logic             bus_idle,
  input  logic             rx,
  output logic             restart,
  output logic             bit_valid,
  output logic             bit_value,
  output logic             tx_bit_start
);
  localparam int CNT_W  = LEN_W + 2;
  localparam int QIDX_W = LEN_W + 3;

  seg_e              seg, seg_nx;
  logic [CNT_W-1:0]  cnt, seg_len, ph1_eff, ph2_eff, rem, sjw_w;
  logic [QIDX_W-1:0] qidx, qidx_n;
  logic [SJW_W-1:0]  ext, cut, ext_n, cut_n, sjw_c, qmin;
  logic              rx_q, resynced, resync_n, fall, hard, soft_ok, last, end_ph1;

  always_comb begin
    sjw_c   = (sjw == '0) ? SJW_W'(1) : sjw;
    sjw_w   = CNT_W'(sjw_c);
    fall    = rx_q & ~rx;
    hard    = fall & bus_idle;
    soft_ok = fall & ~bus_idle & ~resynced & (seg != SEG_SYNC);
    rem     = (CNT_W'(ph2c) > cnt) ? CNT_W'(ph2c) - cnt : CNT_W'(1);
    restart = hard | (soft_ok && seg == SEG_PH2 && rem <= sjw_w);
    qmin    = (qidx < QIDX_W'(sjw_c)) ? SJW_W'(qidx) : sjw_c;
    ext_n   = (soft_ok && (seg == SEG_PROP || seg == SEG_PH1)) ? qmin : ext;
    cut_n   = (soft_ok && seg == SEG_PH2 && rem > sjw_w) ? sjw_c : cut;
    resync_n = resynced | soft_ok;
    ph1_eff = CNT_W'(ph1c) + CNT_W'(ext_n);
    ph2_eff = CNT_W'(ph2c) - CNT_W'(cut_n);
    unique case (seg)
      SEG_SYNC: begin seg_len = CNT_W'(1); seg_nx = SEG_PROP; end
      SEG_PROP: begin seg_len = CNT_W'(propc); seg_nx = SEG_PH1; end
      SEG_PH1:  begin seg_len = ph1_eff; seg_nx = SEG_PH2; end
      default:  begin seg_len = ph2_eff; seg_nx = SEG_SYNC; end
    endcase
    last    = (cnt >= seg_len - CNT_W'(1));
    end_ph1 = tick && seg == SEG_PH1 && last && !restart;
    qidx_n  = (last && seg == SEG_PH2) ? '0 : qidx + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_q <= 1'b1; seg <= SEG_SYNC; cnt <= '0; qidx <= '0;
      ext <= '0; cut <= '0; resynced <= 1'b0;
      bit_valid <= 1'b0; bit_value <= 1'b0; tx_bit_start <= 1'b0;
    end else begin
      rx_q      <= rx;
      bit_valid <= end_ph1;
      if (end_ph1) bit_value <= rx;
      if (restart) begin
        seg <= SEG_SYNC; cnt <= '0; qidx <= '0;
        ext <= '0; cut <= '0; resynced <= 1'b0;
        tx_bit_start <= (tx_dly == 2'd0);
      end else begin
        tx_bit_start <= tick && (qidx_n == QIDX_W'(tx_dly));
        if (tick && last && seg == SEG_PH2) begin
          seg <= SEG_SYNC; cnt <= '0; qidx <= '0;
          ext <= '0; cut <= '0; resynced <= 1'b0;
        end else begin
          ext <= ext_n; cut <= cut_n; resynced <= resync_n;
          if (tick) begin
            qidx <= qidx_n;
            if (last) begin seg <= seg_nx; cnt <= '0; end
            else cnt <= cnt + 1'b1;
          end
        end
      end
    end
  end

  // R2
  sample_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |=> !bit_valid);
  // R2
  seg_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seg == SEG_PH2 && !restart) |=> (seg == SEG_PH2 || seg == SEG_SYNC));
  // R6
  restart_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (seg == SEG_SYNC && cnt == '0));
  // R7
  jump_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resynced && $stable(sjw)) |-> (ext <= sjw_c && cut <= sjw_c));
  // R9
  one_resync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resynced && !restart && !(tick && last && seg == SEG_PH2)) |=> ($stable(ext) && $stable(cut)));
endmodule

// File: rtl/can_bittime_gen.sv
module can_bittime_gen #(
  parameter int PRESC_W      = 6,
  parameter int LEN_W        = 4,
  parameter int SJW_W        = 3,
  parameter int MIN_BIT_CLKS = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PRESC_W-1:0] presc,
  input  logic [LEN_W-1:0]   prop_len,
  input  logic [LEN_W-1:0]   ph1_len,
  input  logic [LEN_W-1:0]   ph2_len,
  input  logic [SJW_W-1:0]   sjw,
  input  logic               bus_idle,
  input  logic               rx,
  output logic               tq_tick,
  output logic               bit_valid,
  output logic               bit_value,
  output logic               tx_bit_start,
  output logic               cfg_err
);
  logic [LEN_W-1:0] propc, ph1c, ph2c;
  logic [1:0]       tx_dly;
  logic             restart;

  assign propc = (prop_len == '0) ? LEN_W'(1) : prop_len;
  assign ph1c  = (ph1_len  == '0) ? LEN_W'(1) : ph1_len;
  assign ph2c  = (ph2_len  == '0) ? LEN_W'(1) : ph2_len;

  cbt_tq_div #(.PRESC_W(PRESC_W)) u_div (
    .clk(clk), .rst_n(rst_n), .presc(presc), .restart(restart), .tick(tq_tick)
  );

  cbt_cfg_chk #(.PRESC_W(PRESC_W), .LEN_W(LEN_W), .MIN_BIT_CLKS(MIN_BIT_CLKS)) u_cfg (
    .presc(presc), .ph2_raw(ph2_len), .propc(propc), .ph1c(ph1c), .ph2c(ph2c),
    .cfg_err(cfg_err), .tx_dly(tx_dly)
  );

  cbt_seq #(.LEN_W(LEN_W), .SJW_W(SJW_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .tick(tq_tick), .propc(propc), .ph1c(ph1c), .ph2c(ph2c),
    .sjw(sjw), .tx_dly(tx_dly), .bus_idle(bus_idle), .rx(rx), .restart(restart),
    .bit_valid(bit_valid), .bit_value(bit_value), .tx_bit_start(tx_bit_start)
  );

  // R3
  tx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_bit_start && !restart) |=> !tx_bit_start);
endmodule

// File: tb/can_bittime_gen_tb_top.sv
`timescale 1ns/1ps
module can_bittime_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] presc = '0;
  logic [3:0] prop_len = 4'd1, ph1_len = 4'd1, ph2_len = 4'd1;
  logic [2:0] sjw = 3'd1;
  logic       bus_idle = 1'b0, rx = 1'b1;
  logic       tq_tick, bit_valid, bit_value, tx_bit_start, cfg_err;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  can_bittime_gen dut_i (
    .clk(clk), .rst_n(rst_n), .presc(presc), .prop_len(prop_len), .ph1_len(ph1_len),
    .ph2_len(ph2_len), .sjw(sjw), .bus_idle(bus_idle), .rx(rx), .tq_tick(tq_tick),
    .bit_valid(bit_valid), .bit_value(bit_value), .tx_bit_start(tx_bit_start), .cfg_err(cfg_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setup(input int p, input int pr, input int p1, input int p2, input int s, input bit idle);
    @(negedge clk);
    rst_n = 1'b0; presc = 6'(p); prop_len = 4'(pr); ph1_len = 4'(p1); ph2_len = 4'(p2);
    sjw = 3'(s); bus_idle = idle; rx = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // which: 0 tick, 1 bit_valid, 2 tx_bit_start
  task automatic wait_evt(input int which, output bit ok);
    ok = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if ((which == 0 && tq_tick) || (which == 1 && bit_valid) || (which == 2 && tx_bit_start)) begin
        ok = 1;
        break;
      end
    end
    if (!ok) chk("timeout", 0, 1);
  endtask

  task automatic t_reset();
    setup(3, 2, 3, 3, 1, 0);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R10 bit_valid", bit_valid, 0);
    chk("R10 tx_bit_start", tx_bit_start, 0);
    chk("R10 bit_value", bit_value, 0);
    chk("R10 tq_tick", tq_tick, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_cfg();
    setup(0, 8, 8, 0, 1, 0); #1 chk("R4 zero ph2 single-clock", cfg_err, 1);
    setup(1, 8, 8, 0, 1, 0); #1 chk("R4 zero ph2 divided", cfg_err, 0);
    setup(0, 1, 1, 1, 1, 0); #1 chk("R5 4 clocks", cfg_err, 1);
    setup(1, 1, 1, 1, 1, 0); #1 chk("R5 8 clocks", cfg_err, 1);
    setup(1, 1, 1, 2, 1, 0); #1 chk("R5 10 clocks", cfg_err, 0);
    setup(2, 1, 1, 1, 1, 0); #1 chk("R5 12 clocks", cfg_err, 0);
  endtask

  task automatic t_tick(input int p);
    bit ok; int c0;
    setup(p, 6, 7, 6, 1, 0);
    wait_evt(0, ok); c0 = cyc;
    wait_evt(0, ok);
    chk("R1 tick period", cyc - c0, p + 1);
  endtask

  task automatic t_bit(input int p, input int pr, input int p1, input int p2);
    bit ok; int c0, c1;
    setup(p, pr, p1, p2, 1, 0);
    wait_evt(2, ok); c0 = cyc;
    wait_evt(1, ok); c1 = cyc;
    chk("R2 sample offset", c1 - c0, (p + 1) * (1 + pr + p1));
    chk("R2 sample value", bit_value, 1);
    wait_evt(1, ok);
    chk("R2 bit period", cyc - c1, (p + 1) * (1 + pr + p1 + p2));
  endtask

  task automatic t_txdly(input int p, input int p2, input int pr, input int exp);
    bit ok; int c0;
    setup(p, pr, pr, p2, 1, 0);
    wait_evt(1, ok); c0 = cyc;
    wait_evt(2, ok);
    chk("R3 tx delay", cyc - c0, exp);
  endtask

  task automatic t_hard();
    bit ok; int c0;
    setup(1, 2, 3, 3, 1, 1);
    wait_evt(1, ok);
    repeat (2) @(negedge clk);
    rx = 1'b0;
    @(negedge clk);
    chk("R6 restart tx", tx_bit_start, 1);
    c0 = cyc;
    wait_evt(1, ok);
    chk("R6 sample after hard sync", cyc - c0, 12);
    chk("R6 sample value", bit_value, 0);
  endtask

  task automatic t_ph1();
    bit ok; int c0;
    setup(0, 2, 3, 4, 2, 0);
    wait_evt(2, ok); c0 = cyc;
    repeat (4) @(negedge clk); rx = 1'b0;
    @(negedge clk); rx = 1'b1;
    @(negedge clk); rx = 1'b0;
    wait_evt(1, ok);
    chk("R7 lengthened sample", cyc - c0, 8);
    chk("R9 second edge ignored, value", bit_value, 0);
    wait_evt(2, ok);
    chk("R7 lengthened bit", cyc - c0, 12);
  endtask

  task automatic t_ph2(input int q, input int exp, input string req);
    bit ok; int c0;
    setup(0, 2, 3, 4, 2, 0);
    wait_evt(2, ok); c0 = cyc;
    wait_evt(1, ok);
    chk("R9 rising ignored, sample", cyc - c0, 6);
    repeat (q - 6) @(negedge clk);
    rx = 1'b0;
    wait_evt(2, ok);
    chk(req, cyc - c0, exp);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_cfg();
    t_tick(3);
    t_tick(9);
    t_bit(0, 8, 8, 8);
    t_bit(9, 6, 7, 6);
    t_txdly(0, 2, 3, 3);
    t_txdly(1, 2, 3, 4);
    t_txdly(0, 1, 4, 3);
    t_hard();
    t_ph1();
    t_ph2(6, 8, "R8 phase 2 trimmed");
    t_ph2(8, 9, "R8 phase 2 restart");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule